// File: doc/BRIEF.md
# Programmable Sum-of-Products Fabric with Output Feedback

This block is a small programmable logic fabric. Each output is the OR of a fixed, private group of product terms, and each product term is a programmable AND over the primary inputs and the block's own outputs, taken in both polarities. The OR wiring is fixed, so an output can use only the terms in its own group. Each output can also be inverted by a programmable polarity bit, which makes product-of-sums forms available. Because outputs feed back into the AND array, multilevel functions can be built inside one fabric.

Configuration lives in two register banks. A word-addressed write port fills a staging bank with one word per product term, plus one word for the output polarities. A single-cycle apply pulse copies the whole staging bank into the active bank that drives evaluation. The staging bank can be read back at any time through a combinational read port. Evaluation from the input pins to the output pins is purely combinational. An output whose terms reach back to itself through feedback, directly or through other outputs, is reported on an error line and is held at 0. Outputs that depend on such an output see it as 0.

Top module: `pal_fabric`

## Requirements
- R1: After reset every staging word reads back as 0, every output pin is 0 and no loop error is reported.
- R2: A write to a term address 0..8 or to the polarity address 9 is visible on the readback port from the next cycle. The polarity word keeps only its low 3 bits. Writes to addresses 10..15 are dropped, and those addresses read back as 0.
- R3: Writes change only the staging bank. Output pins follow the new configuration only after an apply pulse, from the clock edge that samples the pulse.
- R4: A term word is {enable at bit 14, mask at bits 13:0}. Mask bit 2i selects input i true and bit 2i+1 selects input i complemented; bit 8+2k selects output k true and bit 9+2k selects it complemented. An enabled term is the AND of its selected literals, so an empty mask gives 1 and a mask holding both polarities of one signal gives 0. A disabled term is 0 whatever its mask.
- R5: Output k is the OR of terms 3k, 3k+1 and 3k+2 only. Terms of other outputs have no effect on it.
- R6: Bit k of the polarity word inverts output k after its OR.
- R7: Feedback literals carry the final output pin values, so one output can be built from the others.
- R8: An output whose enabled terms connect, directly or through other outputs, to either polarity of itself sets its bit of the loop error vector and is held at 0. Outputs outside the cycle are unaffected, and outputs that only read a cyclic output see it as 0.
- R9: With A, B, C on inputs 0, 1, 2, the fabric realises F1 = A'B' + C' on output 0 and F2 = A'BC' + AC + AB' on output 1 over every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Write address: term index or polarity word |
| cfg_wdata | input | 15 | Write data: enable and literal mask, or polarity bits |
| cfg_apply | input | 1 | Copies the staging bank into the active bank |
| rd_addr | input | 4 | Readback address |
| rd_data | output | 15 | Staging word at rd_addr |
| in_pins | input | 4 | Primary inputs |
| out_pins | output | 3 | Fabric outputs |
| loop_err | output | 3 | Per-output self-dependency flag |

## Verification
Readback shows a write one clock edge after the write strobe is sampled, and the pins and loop flags show an applied configuration one edge after the apply pulse is sampled. A change on the input pins shows on the outputs within the same cycle. The bench drives every input on the falling edge and samples one nanosecond later. This puts each sample after the edge that made the result due and before the next rising edge. Configuration checks are therefore taken at the falling edge after the write or apply, and combinational checks right after the pins settle.

// File: rtl/pal_pkg.sv
// Package: shared defaults and address decoding for the fabric.
// Assumes term words sit at addresses 0..NT-1 and the polarity word at NT.
package pal_pkg;

    localparam int DEF_N_IN = 4;
    localparam int DEF_N_OUT = 3;
    localparam int DEF_TPO = 3;

    typedef enum logic [1:0] {
        ADDR_TERM = 2'd0,
        ADDR_POL  = 2'd1,
        ADDR_NONE = 2'd2
    } addr_kind_e;

    // Classify a configuration address against the number of terms.
    function automatic addr_kind_e classify(input int unsigned addr, input int unsigned n_terms);
        if (addr < n_terms)       return ADDR_TERM;
        else if (addr == n_terms) return ADDR_POL;
        else                      return ADDR_NONE;
    endfunction

endpackage

// File: rtl/pal_cfg_store.sv
// Configuration store: a staging bank written one word at a time and read
// back combinationally, and an active bank loaded from it by an apply pulse.
// Assumes a write and an apply in the same cycle: the write lands in staging,
// and active takes the staging contents from before that write.
module pal_cfg_store
    import pal_pkg::*;
#(
    parameter int N_IN = DEF_N_IN,
    parameter int N_OUT = DEF_N_OUT,
    parameter int TPO = DEF_TPO,
    localparam int NT = N_OUT * TPO,
    localparam int NLIT = 2 * (N_IN + N_OUT),
    localparam int WORD_W = NLIT + 1,
    localparam int ADDR_W = $clog2(NT + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [WORD_W-1:0]         wdata,
    input  logic                      apply,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [WORD_W-1:0]         rdata,
    output logic [NT-1:0]             act_en,
    output logic [NT-1:0][NLIT-1:0]   act_mask,
    output logic [N_OUT-1:0]          act_pol
);

    logic [NT-1:0]           stg_en;
    logic [NT-1:0][NLIT-1:0] stg_mask;
    logic [N_OUT-1:0]        stg_pol;

    // Staging bank: reset clears, writes update the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_en   <= '0;
            stg_mask <= '0;
            stg_pol  <= '0;
        end else if (we) begin
            case (classify(int'(waddr), NT))
                ADDR_TERM: begin
                    stg_en[waddr]   <= wdata[NLIT];
                    stg_mask[waddr] <= wdata[NLIT-1:0];
                end
                ADDR_POL:  stg_pol <= wdata[N_OUT-1:0];
                default:   ;
            endcase
        end
    end

    // Active bank: reset clears, apply copies the whole staging bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en   <= '0;
            act_mask <= '0;
            act_pol  <= '0;
        end else if (apply) begin
            act_en   <= stg_en;
            act_mask <= stg_mask;
            act_pol  <= stg_pol;
        end
    end

    // Readback of the staging word at raddr, zero outside the map.
    always_comb begin
        rdata = '0;
        case (classify(int'(raddr), NT))
            ADDR_TERM: rdata = {stg_en[raddr], stg_mask[raddr]};
            ADDR_POL:  rdata[N_OUT-1:0] = stg_pol;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/pal_loop_check.sv
// Loop check: builds the output-to-output dependency graph from the active
// terms and flags every output that reaches itself.
// Assumes a connection counts structurally, whatever the product evaluates to.
module pal_loop_check
    import pal_pkg::*;
#(
    parameter int N_IN = DEF_N_IN,
    parameter int N_OUT = DEF_N_OUT,
    parameter int TPO = DEF_TPO,
    localparam int NT = N_OUT * TPO,
    localparam int NLIT = 2 * (N_IN + N_OUT)
) (
    input  logic [NT-1:0]           en,
    input  logic [NT-1:0][NLIT-1:0] mask,
    output logic [N_OUT-1:0]        loop
);

    logic [N_OUT-1:0][N_OUT-1:0] dep;
    logic [N_OUT-1:0][N_OUT-1:0] reach;

    // Direct edges: output j reads output k through an enabled term.
    always_comb begin
        dep = '0;
        for (int j = 0; j < N_OUT; j++) begin
            for (int s = 0; s < TPO; s++) begin
                for (int k = 0; k < N_OUT; k++) begin
                    if (en[j*TPO+s] && (mask[j*TPO+s][2*(N_IN+k)] || mask[j*TPO+s][2*(N_IN+k)+1]))
                        dep[j][k] = 1'b1;
                end
            end
        end
    end

    // Transitive closure by repeated path extension, then the diagonal.
    always_comb begin
        reach = dep;
        for (int it = 0; it < N_OUT; it++) begin
            for (int j = 0; j < N_OUT; j++) begin
                for (int k = 0; k < N_OUT; k++) begin
                    if (reach[j][k]) reach[j] = reach[j] | reach[k];
                end
            end
        end
        for (int j = 0; j < N_OUT; j++) loop[j] = reach[j][j];
    end

endmodule

// File: rtl/pal_eval.sv
// Evaluator: combinational AND array, fixed OR groups, output polarity.
// Feedback is resolved by N_OUT unrolled passes; pass 0 sees feedback as 0.
// Assumes cyclic outputs are already flagged, so forcing them to 0 in every
// pass makes the final pass exact for all acyclic outputs.
module pal_eval
    import pal_pkg::*;
#(
    parameter int N_IN = DEF_N_IN,
    parameter int N_OUT = DEF_N_OUT,
    parameter int TPO = DEF_TPO,
    localparam int NT = N_OUT * TPO,
    localparam int NLIT = 2 * (N_IN + N_OUT),
    localparam int NPASS = N_OUT
) (
    input  logic [N_IN-1:0]         pins,
    input  logic [NT-1:0]           en,
    input  logic [NT-1:0][NLIT-1:0] mask,
    input  logic [N_OUT-1:0]        pol,
    input  logic [N_OUT-1:0]        loop,
    output logic [N_OUT-1:0]        result
);

    logic [NPASS:0][N_OUT-1:0] stage;

    assign stage[0] = '0;

    for (genvar p = 0; p < NPASS; p++) begin : g_pass
        logic [NLIT-1:0]  lits;
        logic [NT-1:0]    prod;
        logic [N_OUT-1:0] sum;

        // Literal vector: both polarities of pins, then of the feedback.
        always_comb begin
            for (int i = 0; i < N_IN; i++) begin
                lits[2*i]   = pins[i];
                lits[2*i+1] = ~pins[i];
            end
            for (int k = 0; k < N_OUT; k++) begin
                lits[2*(N_IN+k)]   = stage[p][k];
                lits[2*(N_IN+k)+1] = ~stage[p][k];
            end
        end

        for (genvar t = 0; t < NT; t++) begin : g_term
            assign prod[t] = en[t] & (&(~mask[t] | lits));
        end

        for (genvar o = 0; o < N_OUT; o++) begin : g_or
            assign sum[o] = |prod[o*TPO +: TPO];
        end

        assign stage[p+1] = (sum ^ pol) & ~loop;
    end

    assign result = stage[NPASS];

endmodule

// File: rtl/pal_fabric.sv
// Top: programmable AND array with fixed OR groups and output feedback.
// Assumes synchronous active-low reset; evaluation itself is combinational.
module pal_fabric
    import pal_pkg::*;
#(
    parameter int N_IN = DEF_N_IN,
    parameter int N_OUT = DEF_N_OUT,
    parameter int TPO = DEF_TPO,
    localparam int NT = N_OUT * TPO,
    localparam int NLIT = 2 * (N_IN + N_OUT),
    localparam int WORD_W = NLIT + 1,
    localparam int ADDR_W = $clog2(NT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              cfg_apply,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic [N_IN-1:0]   in_pins,
    output logic [N_OUT-1:0]  out_pins,
    output logic [N_OUT-1:0]  loop_err
);

    logic [NT-1:0]           act_en;
    logic [NT-1:0][NLIT-1:0] act_mask;
    logic [N_OUT-1:0]        act_pol;

    pal_cfg_store #(.N_IN(N_IN), .N_OUT(N_OUT), .TPO(TPO)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .waddr    (cfg_addr),
        .wdata    (cfg_wdata),
        .apply    (cfg_apply),
        .raddr    (rd_addr),
        .rdata    (rd_data),
        .act_en   (act_en),
        .act_mask (act_mask),
        .act_pol  (act_pol)
    );

    pal_loop_check #(.N_IN(N_IN), .N_OUT(N_OUT), .TPO(TPO)) u_loop (
        .en   (act_en),
        .mask (act_mask),
        .loop (loop_err)
    );

    pal_eval #(.N_IN(N_IN), .N_OUT(N_OUT), .TPO(TPO)) u_eval (
        .pins   (in_pins),
        .en     (act_en),
        .mask   (act_mask),
        .pol    (act_pol),
        .loop   (loop_err),
        .result (out_pins)
    );

endmodule

// File: rtl/pal_fabric_chk.sv
// Checker: temporal properties of the fabric, bound to every pal_fabric.
module pal_fabric_chk #(
    parameter int N_IN = 4,
    parameter int N_OUT = 3,
    parameter int TPO = 3,
    localparam int NT = N_OUT * TPO,
    localparam int NLIT = 2 * (N_IN + N_OUT),
    localparam int WORD_W = NLIT + 1,
    localparam int ADDR_W = $clog2(NT + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [WORD_W-1:0] cfg_wdata,
    input logic              cfg_apply,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input logic [N_IN-1:0]   in_pins,
    input logic [N_OUT-1:0]  out_pins,
    input logic [N_OUT-1:0]  loop_err
);

    // R2: a term written last cycle reads back unchanged.
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && ($past(cfg_addr) < ADDR_W'(NT)) && (rd_addr == $past(cfg_addr)))
        |-> (rd_data == $past(cfg_wdata)));

    // R2: addresses beyond the polarity word read as zero.
    a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > ADDR_W'(NT)) |-> (rd_data == '0));

    // R3: without an apply and with steady pins, outputs hold.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_apply) && $stable(in_pins)) |-> $stable(out_pins));

    // R3: without an apply, loop flags hold.
    a_r3_loop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_apply)) |-> $stable(loop_err));

    // R8: a flagged output is never high.
    a_r8_loop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_pins & loop_err) == '0));

endmodule

bind pal_fabric pal_fabric_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .TPO(TPO)) u_chk (.*);

// File: tb/sim_pal_fabric.sv
module sim_pal_fabric;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [14:0] cfg_wdata = '0;
    logic        cfg_apply = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [14:0] rd_data;
    logic [3:0]  in_pins = '0;
    logic [2:0]  out_pins;
    logic [2:0]  loop_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pal_fabric u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_apply(cfg_apply), .rd_addr(rd_addr),
        .rd_data(rd_data), .in_pins(in_pins), .out_pins(out_pins), .loop_err(loop_err)
    );

    // Literal bit positions: input i true 2i, complement 2i+1; output k true 8+2k.
    function automatic logic [13:0] lt(input int i);   return 14'(1) << (2*i);       endfunction
    function automatic logic [13:0] lc(input int i);   return 14'(1) << (2*i+1);     endfunction
    function automatic logic [13:0] ft(input int k);   return 14'(1) << (8+2*k);     endfunction
    function automatic logic [13:0] fc(input int k);   return 14'(1) << (9+2*k);     endfunction
    function automatic logic [14:0] on(input logic [13:0] m); return {1'b1, m};       endfunction

    task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [14:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic apply_cfg();
        @(negedge clk); cfg_apply = 1'b1;
        @(negedge clk); cfg_apply = 1'b0; #1;
    endtask

    task automatic drive(input logic [3:0] v);
        in_pins = v; #1;
    endtask

    task automatic clear_all();
        for (int a = 0; a <= 9; a++) wr(4'(a), '0);
        apply_cfg();
    endtask

    // R1: reset state of readback, outputs and flags.
    task automatic t_reset();
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a); #1;
            check("R1 readback", rd_data, '0);
        end
        drive(4'hF);
        check("R1 outputs", 15'(out_pins), '0);
        check("R1 loop flags", 15'(loop_err), '0);
    endtask

    // R2: write, readback, polarity width, dropped addresses.
    task automatic t_readback();
        wr(4'd2, 15'h5A3C);
        rd_addr = 4'd2; #1;
        check("R2 term readback", rd_data, 15'h5A3C);
        wr(4'd9, 15'h7FFF);
        rd_addr = 4'd9; #1;
        check("R2 polarity readback", rd_data, 15'h0007);
        wr(4'd12, 15'h1234);
        rd_addr = 4'd12; #1;
        check("R2 dropped address", rd_data, '0);
        rd_addr = 4'd2; #1;
        check("R2 neighbour intact", rd_data, 15'h5A3C);
        clear_all();
    endtask

    // R3: staging does not reach the pins until apply.
    task automatic t_staging();
        drive(4'h0);
        wr(4'd0, on('0));
        check("R3 before apply", 15'(out_pins), 15'b000);
        apply_cfg();
        check("R3 after apply", 15'(out_pins), 15'b001);
        clear_all();
    endtask

    // R4: AND semantics, empty, contradictory and disabled terms.
    task automatic t_terms();
        wr(4'd0, on(lt(0) | lc(1)));      // out0 = in0 & ~in1
        wr(4'd3, on(lt(2) | lc(2)));      // out1 = 0 (both polarities)
        wr(4'd6, {1'b0, lt(3)});          // out2 term disabled
        apply_cfg();
        for (int v = 0; v < 16; v++) begin
            logic e0;
            drive(4'(v));
            e0 = v[0] & ~v[1];
            check("R4 and term / contradiction / disabled", 15'(out_pins), 15'({1'b0, 1'b0, e0}));
        end
        clear_all();
    endtask

    // R5: a term drives only its own output group.
    task automatic t_groups();
        wr(4'd5, on('0));                 // last slot of output 1
        apply_cfg();
        drive(4'h3);
        check("R5 slot 5 owns output 1", 15'(out_pins), 15'b010);
        wr(4'd5, '0);
        wr(4'd6, on('0));                 // first slot of output 2
        apply_cfg();
        check("R5 slot 6 owns output 2", 15'(out_pins), 15'b100);
        clear_all();
    endtask

    // R6: per-output inversion, giving a NAND on output 2.
    task automatic t_polarity();
        wr(4'd6, on(lt(0) | lt(1)));
        wr(4'd9, 15'b100);
        apply_cfg();
        for (int v = 0; v < 4; v++) begin
            drive(4'(v));
            check("R6 inverted output", 15'(out_pins), 15'({~(v[0] & v[1]), 2'b00}));
        end
        clear_all();
    endtask

    // R9 and R7: textbook functions, then a feedback AND of both.
    task automatic t_functions();
        wr(4'd0, on(lc(0) | lc(1)));
        wr(4'd1, on(lc(2)));
        wr(4'd3, on(lc(0) | lt(1) | lc(2)));
        wr(4'd4, on(lt(0) | lt(2)));
        wr(4'd5, on(lt(0) | lc(1)));
        wr(4'd6, on(ft(0) | ft(1)));
        apply_cfg();
        for (int v = 0; v < 8; v++) begin
            logic a, b, c, f1, f2;
            a = v[0]; b = v[1]; c = v[2];
            drive(4'(v));
            f1 = (~a & ~b) | ~c;
            f2 = (~a & b & ~c) | (a & c) | (a & ~b);
            check("R9 F1 and F2", 15'(out_pins[1:0]), 15'({f2, f1}));
            check("R7 feedback product", 15'(out_pins[2]), 15'(f1 & f2));
        end
        clear_all();
    endtask

    // R8: self loop, two-output cycle, and a reader of a cyclic output.
    task automatic t_loops();
        wr(4'd0, on(ft(0)));
        wr(4'd3, on('0));
        apply_cfg();
        drive(4'h0);
        check("R8 self loop flag", 15'(loop_err), 15'b001);
        check("R8 self loop output", 15'(out_pins), 15'b010);
        clear_all();
        wr(4'd3, on(ft(2)));
        wr(4'd6, on(fc(1)));
        wr(4'd0, on(ft(1) | lc(0)));
        apply_cfg();
        check("R8 cycle flags", 15'(loop_err), 15'b110);
        check("R8 cycle outputs", 15'(out_pins), 15'b000);
        clear_all();
        check("R8 cleared flags", 15'(loop_err), 15'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_readback();
        t_staging();
        t_terms();
        t_groups();
        t_polarity();
        t_functions();
        t_loops();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule